// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Controller

This block gathers up to 64 interrupt sources into one request line for a processor. Each source has its own control byte. The byte enables the source and chooses one of three triggers: active-high level, rising edge or falling edge. Raw inputs are asynchronous. They pass through a two-stage synchroniser before any edge detection. An edge event is caught in a sticky status bit. Software acknowledges the event by writing a one to that bit. A level source requests service for as long as its synchronised input is high and the source is enabled.

An arbiter picks one pending source every cycle. It drives a registered request flag and the registered number of the chosen source. By default the lowest-numbered pending source wins. When software sets the rotate bit in the global control word, the arbiter keeps the current grant while that source stays pending. After that it searches upward from the source above the last grant, wrapping at the top.

The register port is word addressed, 32 bits wide, with byte strobes, and reads are combinational. The byte offset of any register is four times its word address. Control byte n sits at byte offset 0x40+n, that is word 0x10+n/4, lane n%4. The status words are at word 0x20 (sources 0 to 31) and word 0x21 (sources 32 to 63). The global control word is at word 0x08 (byte offset 0x20).

Top module: `irqc_top`

## Requirements
- R1: After reset every control byte, both status words and the global control word read 0, irq_o is 0 and irq_id_o is 0.
- R2: Control byte n is written and read at word 0x10+n/4, in byte lane n%4. Only the lanes whose strobe is set are written. In the byte, bit 3 is the enable and bits 5:4 are the trigger: 0 selects active-high level, 1 rising edge, 2 falling edge, and 3 means the source never requests.
- R3: A level source raises a request only while it is enabled and its synchronised input is 1. Its status bit stays 0.
- R4: A rising edge on a source set to trigger 1 sets its status bit. Sources 0 to 31 use bit n of word 0x20, and sources 32 to 63 use bit n-32 of word 0x21. The bit stays set while the input remains high.
- R5: A falling edge on a source set to trigger 2 sets its status bit. A rising edge on it does not.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. An edge source requests only while its status bit is set and it is enabled.
- R7: If a clear of a status bit and a new edge on that source fall in the same cycle, the bit stays set.
- R8: An edge is latched into the status bit even while its source is disabled. The request appears once the source is enabled.
- R9: With bit 6 of word 0x08 at 0, the lowest-numbered pending source is granted.
- R10: With bit 6 of word 0x08 at 1, a granted source that is still pending keeps the grant. Otherwise the search starts one above the last grant and wraps from 63 to 0.
- R11: irq_o and irq_id_o are registered. A level input that changes just after a clock edge shows on irq_o after the third following edge, not before.
- R12: Reads of words without a register return 0, and writes to them change nothing. This includes word 0x09 (byte offset 0x24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_i | input | 64 | Raw asynchronous interrupt inputs |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 6 | Number of the granted source |

## Verification
The assertions assume a few things about the inputs:
- Reset is asserted before the first edge that counts.
- Every input level the synchroniser must see is held for at least two clock cycles.
- A write is a single-cycle strobe.

The hold-and-search check also assumes that the rotate bit does not change between the cycle a grant is made and the cycle it is checked.

The bench meets these assumptions as follows:
- It drives every input on the falling clock edge.
- It holds each source level for four or more cycles, except in the collision test, which aligns a clear with the cycle the edge is latched.
- It changes the rotate bit only while the grant is steady.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word addresses (byte offset = 4 * word)
    localparam int GCTL_WORD = 'h08;
    localparam int CTRL_WORD = 'h10;
    localparam int STAT_WORD = 'h20;

    // Global control and control-byte field positions
    localparam int ROT_BIT   = 6;
    localparam int LANES     = 4;
    localparam int LANE_W    = 8;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_NONE  = 2'd3
    } trig_e;

    typedef struct packed {
        logic [1:0] spare_hi;
        trig_e      trig;
        logic       en;
        logic [2:0] spare_lo;
    } ctrl_byte_t;

    function automatic logic [LANES*LANE_W-1:0] strb_mask(input logic [LANES-1:0] s);
        logic [LANES*LANE_W-1:0] m;
        for (int b = 0; b < LANES; b++) begin
            m[b*LANE_W +: LANE_W] = {LANE_W{s[b]}};
        end
        return m;
    endfunction

    function automatic logic is_edge(input trig_e t);
        return (t == TRIG_RISE) || (t == TRIG_FALL);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    sync_i,
    input  logic [NUM_SRC-1:0]    en_i,
    input  trig_e [NUM_SRC-1:0]   trig_i,
    input  logic [NUM_SRC-1:0]    clr_i,
    output logic [NUM_SRC-1:0]    status_o,
    output logic [NUM_SRC-1:0]    pend_o
);
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] set_w;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign set_w[i] = ((trig_i[i] == TRIG_RISE) &&  sync_i[i] && !prev_q[i]) ||
                          ((trig_i[i] == TRIG_FALL) && !sync_i[i] &&  prev_q[i]);
        assign pend_o[i] = en_i[i] && ((trig_i[i] == TRIG_LEVEL) ? sync_i[i] :
                                       (is_edge(trig_i[i]) && status_q[i]));
    end

    // set has priority over a simultaneous write-1 clear
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= sync_i;
            status_q <= (status_q & ~clr_i) | set_w;
        end
    end

    assign status_o = status_q;

    // R6: a clear with no competing edge empties the bit
    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_w) != '0) |=> ((status_q & $past(clr_i & ~set_w)) == '0));

    // R7: a new edge always leaves its bit set, clear or not
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (set_w != '0) |=> ((status_q & $past(set_w)) == $past(set_w)));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 64,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rot_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    id_o
);
    logic            irq_q;
    logic [ID_W-1:0] id_q;
    logic [ID_W-1:0] last_q;
    logic [ID_W-1:0] start;
    logic [ID_W-1:0] pick;
    logic [ID_W-1:0] winner;
    logic            found;
    logic            hold;
    int              idx;

    always_comb begin
        if (!rot_i) begin
            start = '0;
        end else if (last_q == ID_W'(NUM_SRC - 1)) begin
            start = '0;
        end else begin
            start = last_q + 1'b1;
        end
        pick  = '0;
        found = 1'b0;
        idx   = 0;
        for (int k = 0; k < NUM_SRC; k++) begin
            idx = int'(start) + k;
            if (idx >= NUM_SRC) idx = idx - NUM_SRC;
            if (!found && pend_i[ID_W'(idx)]) begin
                found = 1'b1;
                pick  = ID_W'(idx);
            end
        end
        hold   = rot_i && irq_q && pend_i[last_q];
        winner = hold ? last_q : pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            id_q   <= '0;
            last_q <= ID_W'(NUM_SRC - 1);
        end else if (|pend_i) begin
            irq_q  <= 1'b1;
            id_q   <= winner;
            last_q <= winner;
        end else begin
            irq_q  <= 1'b0;
        end
    end

    assign irq_o = irq_q;
    assign id_o  = id_q;

    // checker state: pending vector seen by the last grant decision
    logic [NUM_SRC-1:0] pend_d;
    logic               rot_d;
    always_ff @(posedge clk) begin
        pend_d <= pend_i;
        rot_d  <= rot_i;
    end

    // R9: fixed mode grants a pending source with nothing lower pending
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (!rot_i && (|pend_i)) |=> (irq_q && pend_d[id_q] &&
        ((pend_d & ((NUM_SRC'(1) << id_q) - NUM_SRC'(1))) == '0)));

    // R10: rotating mode holds a grant whose source is still pending
    a_r10_hold_grant: assert property (@(posedge clk) disable iff (rst)
        (rot_i && irq_q && pend_i[id_q]) |=> (irq_q && $stable(id_q)));

    // R11: no pending source means the request drops on the next edge
    a_r11_drop: assert property (@(posedge clk) disable iff (rst)
        (pend_i == '0) |=> !irq_q);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int N_STAT = NUM_SRC / DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [LANES-1:0]   bus_wstrb,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o
);
    ctrl_byte_t [NUM_SRC-1:0] ctrl_q;
    logic                     rot_q;
    logic [NUM_SRC-1:0]       sync_w;
    logic [NUM_SRC-1:0]       en_w;
    trig_e [NUM_SRC-1:0]      trig_w;
    logic [NUM_SRC-1:0]       clr_w;
    logic [NUM_SRC-1:0]       status_w;
    logic [NUM_SRC-1:0]       pend_w;
    logic [DATA_W-1:0]        wmask;

    assign wmask = strb_mask(bus_wstrb);

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rot_q  <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(GCTL_WORD) && bus_wstrb[0]) begin
                rot_q <= bus_wdata[ROT_BIT];
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_addr == ADDR_W'(CTRL_WORD + i / LANES) && bus_wstrb[i % LANES]) begin
                    ctrl_q[i] <= bus_wdata[(i % LANES)*LANE_W +: LANE_W];
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_fields
        assign en_w[i]   = ctrl_q[i].en;
        assign trig_w[i] = ctrl_q[i].trig;
    end

    // write-1-to-clear masks for the status words
    always_comb begin
        clr_w = '0;
        for (int w = 0; w < N_STAT; w++) begin
            if (bus_we && bus_addr == ADDR_W'(STAT_WORD + w)) begin
                clr_w[w*DATA_W +: DATA_W] = bus_wdata & wmask;
            end
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(GCTL_WORD)) begin
            bus_rdata[ROT_BIT] = rot_q;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == ADDR_W'(CTRL_WORD + i / LANES)) begin
                bus_rdata[(i % LANES)*LANE_W +: LANE_W] = ctrl_q[i];
            end
        end
        for (int w = 0; w < N_STAT; w++) begin
            if (bus_addr == ADDR_W'(STAT_WORD + w)) begin
                bus_rdata = status_w[w*DATA_W +: DATA_W];
            end
        end
    end

    irqc_sync #(.W(NUM_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (sync_w)
    );

    irqc_trigger #(.NUM_SRC(NUM_SRC)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_w),
        .en_i     (en_w),
        .trig_i   (trig_w),
        .clr_i    (clr_w),
        .status_o (status_w),
        .pend_o   (pend_w)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .rot_i  (rot_q),
        .pend_i (pend_w),
        .irq_o  (irq_o),
        .id_o   (irq_id_o)
    );

    // R3: a level source never leaves a status bit behind
    a_r3_level_no_status: assert property (@(posedge clk) disable iff (rst)
        ((status_w & ~en_w) == (status_w & ~en_w)) && $stable(ctrl_q) |=>
        ((status_w & $past({NUM_SRC{1'b1}} & ~status_w)) & level_mask()) == '0);

    function automatic logic [NUM_SRC-1:0] level_mask();
        logic [NUM_SRC-1:0] m;
        for (int i = 0; i < NUM_SRC; i++) m[i] = (ctrl_q[i].trig == TRIG_LEVEL);
        return m;
    endfunction
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_wstrb;
    logic [31:0] bus_rdata;
    logic [63:0] src_i;
    logic        irq_o;
    logic [5:0]  irq_id_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    irqc_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .bus_rdata (bus_rdata),
        .src_i     (src_i),
        .irq_o     (irq_o),
        .irq_id_o  (irq_id_o)
    );

    // level vectors {src_i, expected irq, expected id}; all sources level-enabled, fixed mode
    localparam logic [70:0] VEC [0:7] = '{
        {64'h0000_0000_0000_0000, 1'b0, 6'd0},
        {64'h0000_0000_0000_0001, 1'b1, 6'd0},
        {64'h8000_0000_0000_0000, 1'b1, 6'd63},
        {64'h0000_0001_0000_0000, 1'b1, 6'd32},
        {64'h0000_0000_8000_0000, 1'b1, 6'd31},
        {64'hF0F0_0000_0000_0010, 1'b1, 6'd4},
        {64'h0100_0000_0000_0000, 1'b1, 6'd56},
        {64'h0000_0000_0000_0000, 1'b0, 6'd0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wstrb = 4'h0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wstrb = '0; src_i = '0;
        ticks(3);
        rst = 1'b0;
        ticks(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung, expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 id", irq_id_o, 0);
        rd(6'h10, d); chk("R1 ctrl", d, 0);
        rd(6'h20, d); chk("R1 stat0", d, 0);
        rd(6'h21, d); chk("R1 stat1", d, 0);
        rd(6'h08, d); chk("R1 gctl", d, 0);

        // R12 unmapped words
        wr(6'h05, 32'hFFFF_FFFF, 4'hF);
        wr(6'h09, 32'hFFFF_FFFF, 4'hF);
        rd(6'h05, d); chk("R12 read 0x05", d, 0);
        rd(6'h09, d); chk("R12 read 0x09", d, 0);
        rd(6'h08, d); chk("R12 gctl untouched", d, 0);
        rd(6'h10, d); chk("R12 ctrl untouched", d, 0);
        ticks(2);
        chk("R12 irq untouched", irq_o, 0);

        // R9 vector table: every source level-enabled, lowest pending wins
        for (int w = 0; w < 16; w++) wr(6'h10 + 6'(w), 32'h0808_0808, 4'hF);
        for (int v = 0; v < 8; v++) begin
            src_i = VEC[v][70:7];
            ticks(5);
            chk($sformatf("R9 vec%0d irq", v), irq_o, VEC[v][6]);
            if (VEC[v][6]) chk($sformatf("R9 vec%0d id", v), irq_id_o, VEC[v][5:0]);
        end

        // R11 latency of a level input
        src_i = 64'h0000_0000_0000_0100;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet after 2 edges", irq_o, 0);
        ticks(1);
        chk("R11 irq after 3 edges", irq_o, 1);
        chk("R11 id", irq_id_o, 8);

        // R3 level gated by enable, no status
        do_reset();
        src_i[5] = 1'b1;
        ticks(5);
        chk("R3 disabled level", irq_o, 0);
        wr(6'h11, 32'h0000_0800, 4'b0010);
        ticks(2);
        chk("R3 enabled level irq", irq_o, 1);
        chk("R3 enabled level id", irq_id_o, 5);
        rd(6'h20, d); chk("R3 level status stays 0", d, 0);

        // R2 byte-lane write and readback (source 10 rising, enabled)
        do_reset();
        wr(6'h12, 32'hFF18_FFFF, 4'b0100);
        rd(6'h12, d); chk("R2 lane readback", d, 32'h0018_0000);

        // R4 rising edge
        src_i[10] = 1'b1;
        ticks(5);
        rd(6'h20, d); chk("R4 status bit10", d, 32'h0000_0400);
        chk("R4 irq", irq_o, 1);
        chk("R4 id", irq_id_o, 10);

        // R6 write-0 keeps, write-1 clears
        wr(6'h20, 32'h0000_0000, 4'hF);
        rd(6'h20, d); chk("R6 write zero keeps", d, 32'h0000_0400);
        wr(6'h20, 32'h0000_0400, 4'hF);
        rd(6'h20, d); chk("R6 write one clears", d, 0);
        ticks(2);
        chk("R6 irq drops with input still high", irq_o, 0);

        // R7 clear and new edge in the same cycle
        src_i[10] = 1'b0;
        ticks(4);
        src_i[10] = 1'b1;
        ticks(4);
        rd(6'h20, d); chk("R7 setup set", d, 32'h0000_0400);
        src_i[10] = 1'b0;
        ticks(4);
        src_i[10] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(6'h20, 32'h0000_0400, 4'hF);
        rd(6'h20, d); chk("R7 edge wins over clear", d, 32'h0000_0400);

        // R5 falling edge on source 40
        do_reset();
        wr(6'h1A, 32'h0000_0028, 4'b0001);
        src_i[40] = 1'b1;
        ticks(5);
        rd(6'h21, d); chk("R5 rise ignored", d, 0);
        src_i[40] = 1'b0;
        ticks(5);
        rd(6'h21, d); chk("R5 fall latched", d, 32'h0000_0100);
        chk("R5 irq id", irq_id_o, 40);

        // R8 edge latched while disabled
        do_reset();
        wr(6'h15, 32'h0000_0010, 4'b0001);
        src_i[20] = 1'b1;
        ticks(5);
        rd(6'h20, d); chk("R8 latched while disabled", d, 32'h0010_0000);
        chk("R8 no irq while disabled", irq_o, 0);
        wr(6'h15, 32'h0000_0018, 4'b0001);
        ticks(2);
        chk("R8 irq after enable", irq_o, 1);
        chk("R8 id after enable", irq_id_o, 20);

        // R9 / R10 fixed versus rotating (sources 3 and 9 level-enabled)
        do_reset();
        wr(6'h10, 32'h0800_0000, 4'b1000);
        wr(6'h12, 32'h0000_0800, 4'b0010);
        src_i[3] = 1'b1; src_i[9] = 1'b1;
        ticks(5);
        chk("R9 both pending", irq_id_o, 3);
        src_i[3] = 1'b0; ticks(5);
        chk("R9 after drop", irq_id_o, 9);
        src_i[3] = 1'b1; ticks(5);
        chk("R9 lower returns and wins", irq_id_o, 3);
        wr(6'h08, 32'h0000_0040, 4'h1);
        rd(6'h08, d); chk("R10 rotate bit", d, 32'h0000_0040);
        ticks(3);
        chk("R10 hold current", irq_id_o, 3);
        src_i[3] = 1'b0; ticks(5);
        chk("R10 search above", irq_id_o, 9);
        src_i[3] = 1'b1; ticks(5);
        chk("R10 keep grant", irq_id_o, 9);
        src_i[9] = 1'b0; ticks(5);
        chk("R10 wrap to low", irq_id_o, 3);
        chk("R10 irq", irq_o, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule